// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Level and Error Flags

This block buffers audio samples between a register bus and a serial audio engine. It holds two independent first-in first-out queues of 32 samples each. The transmit queue is filled from the bus side and drained by the serializer. The receive queue is filled by the serializer and drained from the bus side. Each queue reports its fill level as a 6-bit count, so it can show every value from 0 to 32.

Two sticky level flags tell software or a DMA engine when to service the block. The transmit level flag reports enough free room for a refill. The receive level flag reports enough stored samples for a read-out. Each threshold is a 5-bit value T that requests service at T+1 samples, so T = 0 asks for service at every single sample. Four sticky error flags record an underflow or an overflow on either queue. Each error flag must be cleared by software, and the recovery expected after any error is to reset both queues. Every flag has its own interrupt enable, and the single interrupt output combines all of them.

All four data interfaces use valid/ready. A sample moves only in a cycle where both valid and ready are high. A producer may present a sample whether or not ready is high, and it need not hold a refused beat. A beat offered while ready is low is not stored and is counted as an overflow. A consumer that raises ready while valid is low has asked for a sample that does not exist, and this is counted as an underflow. The serializer cannot stall, so ready never has to be waited on.

Top module: `snd_fifo_pair`

## Requirements
- R1: Each queue stores up to 32 samples and returns them in arrival order, including across pointer wrap. A push and a pop in the same cycle leave the count unchanged. `tx_count` and `rx_count` show the current fill level (0 to 32), one cycle after the transfer.
- R2: `tx_in_ready` is low when the transmit queue holds 32 samples or is held in reset. A beat with `tx_in_valid` high while `tx_in_ready` is low is dropped and sets transmit overflow, `flags[3]`, at that clock edge.
- R3: `tx_out_valid` is high when the transmit queue is not empty. `tx_out_ready` high while `tx_out_valid` is low sets transmit underflow, `flags[2]`.
- R4: `rx_in_ready` is low when the receive queue is full or held in reset. A beat offered while it is low is dropped and sets receive overflow, `flags[5]`.
- R5: `rx_out_data` is zero whenever `rx_out_valid` is low. `rx_out_ready` high while the receive queue is empty sets receive underflow, `flags[4]`.
- R6: The transmit level flag `flags[0]` is set one clock after free space (32 minus `tx_count`) is at least `tx_thr`+1. Once set, it stays set.
- R7: The receive level flag `flags[1]` is set one clock after `rx_count` is at least `rx_thr`+1. Once set, it stays set.
- R8: A pulse on `flag_clr[i]` clears `flags[i]` at the next edge. For the level flags (bits 0 and 1) the clear wins, and the flag sets again on the following edge if its condition still holds. For the error flags (bits 2 to 5) a new error in the same cycle wins over the clear.
- R9: While `tx_fifo_rst` is high, the transmit queue is empty with count 0, and both of its ready/valid outputs are low. Beats on its interfaces raise no error flag. `rx_fifo_rst` does the same for the receive queue.
- R10: `irq` is high exactly when some bit of `flags & irq_en` is set. It follows `irq_en` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of all state |
| tx_fifo_rst | input | 1 | Hold transmit queue empty |
| rx_fifo_rst | input | 1 | Hold receive queue empty |
| tx_thr | input | 5 | Transmit level threshold T (service at T+1 free) |
| rx_thr | input | 5 | Receive level threshold T (service at T+1 stored) |
| irq_en | input | 6 | Per-flag interrupt enable |
| flag_clr | input | 6 | Per-flag clear strobe |
| tx_in_valid | input | 1 | Bus sample offered to transmit queue |
| tx_in_data | input | 24 | Bus sample |
| tx_in_ready | output | 1 | Transmit queue can accept |
| tx_out_valid | output | 1 | Transmit sample available to serializer |
| tx_out_data | output | 24 | Transmit sample, zero when none |
| tx_out_ready | input | 1 | Serializer takes a transmit sample |
| rx_in_valid | input | 1 | Serializer offers a received sample |
| rx_in_data | input | 24 | Received sample |
| rx_in_ready | output | 1 | Receive queue can accept |
| rx_out_valid | output | 1 | Received sample available to bus |
| rx_out_data | output | 24 | Received sample, zero when none |
| rx_out_ready | input | 1 | Bus reads a received sample |
| tx_count | output | 6 | Transmit fill level |
| rx_count | output | 6 | Receive fill level |
| flags | output | 6 | Status: 0 tx level, 1 rx level, 2 tx underflow, 3 tx overflow, 4 rx underflow, 5 rx overflow |
| irq | output | 1 | Combined interrupt |

## Verification
The level flags are swept over every threshold 0 to 31 against every fill level 0 to 32 in both queues. This separates an off-by-one in the T+1 rule from a wrong sense of free space against stored count. Ordering is tested with a full fill and drain, and then with a long run of simultaneous push and pop that wraps the pointers. Both tests catch pointer and count slips that a fill-then-drain test alone would miss. Overflow, underflow, clear priority, reset hold and all 64 interrupt-enable patterns are driven one at a time, so each flag bit and each priority rule is checked on its own.

// File: rtl/snd_fifo_pkg.sv
package snd_fifo_pkg;
  localparam int NFLAG = 6;
  localparam int FL_TX_LVL   = 0;
  localparam int FL_RX_LVL   = 1;
  localparam int FL_TX_UNDER = 2;
  localparam int FL_TX_OVER  = 3;
  localparam int FL_RX_UNDER = 4;
  localparam int FL_RX_OVER  = 5;
  // bits where a clear strobe beats a concurrent set
  localparam logic [NFLAG-1:0] LEVEL_MASK = 6'b000011;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/snd_sample_fifo.sv
module snd_sample_fifo #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 24,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic [CW-1:0]     count,
  output logic              over_evt,
  output logic              under_evt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic full, empty, push, pop;

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign in_ready  = !full && !hold_clr;
  assign out_valid = !empty && !hold_clr;
  assign push      = in_valid && in_ready;
  assign pop       = out_ready && out_valid;
  assign out_data  = out_valid ? mem[rp] : '0;
  assign over_evt  = in_valid && !in_ready && !hold_clr;
  assign under_evt = out_ready && !out_valid && !hold_clr;
  assign count     = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (hold_clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R1
  push_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt == $past(cnt) + CW'(1)));
  // R1
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt));
  // R9
  hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr |=> (cnt == '0));
  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> $stable(cnt) || $past(hold_clr));
endmodule

// File: rtl/snd_flag_bank.sv
module snd_flag_bank #(
  parameter int         N        = 6,
  parameter logic [N-1:0] CLR_WINS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] fl;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (CLR_WINS[i]) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fl[i] <= 1'b0;
        else if (clr_i[i]) fl[i] <= 1'b0;
        else if (set_i[i]) fl[i] <= 1'b1;
      end
      // R8
      lvl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i[i] |=> !fl[i]);
    end else begin : g_err
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fl[i] <= 1'b0;
        else if (set_i[i]) fl[i] <= 1'b1;
        else if (clr_i[i]) fl[i] <= 1'b0;
      end
      // R8
      err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> fl[i]);
      // R8
      err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !fl[i]);
    end
  end

  assign flags_o = fl;
  assign irq_o   = |(fl & en_i);
endmodule

// File: rtl/snd_fifo_pair.sv
module snd_fifo_pair
  import snd_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 24,
  localparam int THR_W = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_fifo_rst,
  input  logic              rx_fifo_rst,
  input  logic [THR_W-1:0]  tx_thr,
  input  logic [THR_W-1:0]  rx_thr,
  input  logic [NFLAG-1:0]  irq_en,
  input  logic [NFLAG-1:0]  flag_clr,
  input  logic              tx_in_valid,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_in_ready,
  output logic              tx_out_valid,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              tx_out_ready,
  input  logic              rx_in_valid,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_in_ready,
  output logic              rx_out_valid,
  output logic [DATA_W-1:0] rx_out_data,
  input  logic              rx_out_ready,
  output logic [CW-1:0]     tx_count,
  output logic [CW-1:0]     rx_count,
  output logic [NFLAG-1:0]  flags,
  output logic              irq
);
  logic tx_over, tx_under, rx_over, rx_under;
  logic [CW-1:0] tx_free;
  flag_vec_t set_vec;

  snd_sample_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .hold_clr(tx_fifo_rst),
    .in_valid(tx_in_valid), .in_data(tx_in_data), .in_ready(tx_in_ready),
    .out_valid(tx_out_valid), .out_data(tx_out_data), .out_ready(tx_out_ready),
    .count(tx_count), .over_evt(tx_over), .under_evt(tx_under));

  snd_sample_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .hold_clr(rx_fifo_rst),
    .in_valid(rx_in_valid), .in_data(rx_in_data), .in_ready(rx_in_ready),
    .out_valid(rx_out_valid), .out_data(rx_out_data), .out_ready(rx_out_ready),
    .count(rx_count), .over_evt(rx_over), .under_evt(rx_under));

  assign tx_free = CW'(DEPTH) - tx_count;

  always_comb begin
    set_vec              = '0;
    set_vec[FL_TX_LVL]   = tx_free  >= (CW'(tx_thr) + CW'(1));
    set_vec[FL_RX_LVL]   = rx_count >= (CW'(rx_thr) + CW'(1));
    set_vec[FL_TX_UNDER] = tx_under;
    set_vec[FL_TX_OVER]  = tx_over;
    set_vec[FL_RX_UNDER] = rx_under;
    set_vec[FL_RX_OVER]  = rx_over;
  end

  snd_flag_bank #(.N(NFLAG), .CLR_WINS(LEVEL_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(flag_clr),
    .en_i(irq_en), .flags_o(flags), .irq_o(irq));

  // R5
  rx_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> (rx_out_data == '0));
  // R2
  tx_over_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && !tx_in_ready && !tx_fifo_rst) |=> flags[FL_TX_OVER]);
  // R9
  rx_hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_rst |-> (!rx_in_ready && !rx_out_valid));
endmodule

// File: tb/sim_snd_fifo_pair.sv
module sim_snd_fifo_pair;
  localparam int D = 32;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_fifo_rst = 1'b0, rx_fifo_rst = 1'b0;
  logic [4:0] tx_thr = '0, rx_thr = '0;
  logic [5:0] irq_en = '0, flag_clr = '0;
  logic tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [W-1:0] tx_in_data = '0, rx_in_data = '0;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid, irq;
  logic [W-1:0] tx_out_data, rx_out_data;
  logic [5:0] tx_count, rx_count, flags;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  snd_fifo_pair u0 (.*);

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reset_queues();
    tx_fifo_rst = 1'b1; rx_fifo_rst = 1'b1;
    tick();
    tx_fifo_rst = 1'b0; rx_fifo_rst = 1'b0;
  endtask

  task automatic clear_flags(input logic [5:0] m);
    flag_clr = m;
    tick();
    flag_clr = '0;
  endtask

  function automatic logic [W-1:0] pat(input int i, input int s);
    return W'(i * 37 + s * 1001 + 5);
  endfunction

  initial begin
    @(negedge clk);
    // R9 reset state
    check("R9 reset tx_count", tx_count, 0);
    check("R9 reset rx_count", rx_count, 0);
    check("R8 reset flags", flags, 0);
    check("R10 reset irq", irq, 0);
    tick();
    rst_n = 1'b1;
    tick();

    // R6 R7 R1: every threshold against every fill level
    for (int t = 0; t < D; t++) begin
      tx_thr = 5'(t); rx_thr = 5'(t);
      reset_queues();
      for (int n = 0; n <= D; n++) begin
        clear_flags(6'b000011);
        tick();
        check("R7 rx level flag", flags[1], (n >= t + 1) ? 1 : 0);
        check("R6 tx level flag", flags[0], ((D - n) >= t + 1) ? 1 : 0);
        check("R1 rx_count", rx_count, n);
        check("R1 tx_count", tx_count, n);
        if (n < D) begin
          tx_in_valid = 1'b1; rx_in_valid = 1'b1;
          tx_in_data = pat(n, t); rx_in_data = pat(n, t);
          tick();
          tx_in_valid = 1'b0; rx_in_valid = 1'b0;
        end
      end
      check("R2/R4 no overflow during sweep", flags[5:2], 0);
    end

    // R1 R2 R4: full fill, refused beats, ordered drain
    tx_thr = 5'd31; rx_thr = 5'd31;
    reset_queues();
    clear_flags(6'b111111);
    for (int i = 0; i < D; i++) begin
      tx_in_valid = 1'b1; rx_in_valid = 1'b1;
      tx_in_data = pat(i, 1); rx_in_data = pat(i, 2);
      tick();
    end
    check("R2 tx_in_ready low when full", tx_in_ready, 0);
    check("R4 rx_in_ready low when full", rx_in_ready, 0);
    check("R2 no tx overflow yet", flags[3], 0);
    tx_in_data = 24'hABCDEF; rx_in_data = 24'h123456;
    tick();
    tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    check("R2 tx overflow flag", flags[3], 1);
    check("R4 rx overflow flag", flags[5], 1);
    check("R2 tx count held at 32", tx_count, D);
    check("R4 rx count held at 32", rx_count, D);
    for (int i = 0; i < D; i++) begin
      check("R3 tx_out_valid", tx_out_valid, 1);
      check("R1 tx order", tx_out_data, pat(i, 1));
      check("R1 rx order", rx_out_data, pat(i, 2));
      tx_out_ready = 1'b1; rx_out_ready = 1'b1;
      tick();
      tx_out_ready = 1'b0; rx_out_ready = 1'b0;
    end
    check("R1 tx drained", tx_count, 0);
    check("R3 tx_out_valid empty", tx_out_valid, 0);
    check("R5 rx data zero empty", rx_out_data, 0);
    check("R3 no tx underflow yet", flags[2], 0);
    tx_out_ready = 1'b1; rx_out_ready = 1'b1;
    tick();
    tx_out_ready = 1'b0; rx_out_ready = 1'b0;
    check("R3 tx underflow flag", flags[2], 1);
    check("R5 rx underflow flag", flags[4], 1);
    check("R5 rx data still zero", rx_out_data, 0);

    // R1: concurrent push/pop with pointer wrap
    reset_queues();
    for (int i = 0; i < 20; i++) begin
      tx_in_valid = 1'b1; tx_in_data = pat(i, 3);
      tick();
    end
    for (int i = 0; i < 60; i++) begin
      check("R1 wrap order", tx_out_data, pat(i, 3));
      tx_in_valid = 1'b1; tx_in_data = pat(i + 20, 3);
      tx_out_ready = 1'b1;
      tick();
      check("R1 push+pop count", tx_count, 20);
    end
    tx_in_valid = 1'b0; tx_out_ready = 1'b0;

    // R8: clear priorities
    clear_flags(6'b111100);
    check("R8 errors cleared", flags[5:2], 0);
    reset_queues();
    tick();
    check("R6 tx level set when empty", flags[0], 1);
    flag_clr = 6'b000001;
    tick();
    flag_clr = '0;
    check("R8 level clear wins", flags[0], 0);
    tick();
    check("R8 level re-sets", flags[0], 1);
    tx_out_ready = 1'b1; flag_clr = 6'b000100;
    tick();
    tx_out_ready = 1'b0; flag_clr = '0;
    check("R8 error set beats clear", flags[2], 1);

    // R10: interrupt combine over all enables, flags pattern 010101
    rx_out_ready = 1'b1;
    tick();
    rx_out_ready = 1'b0;
    clear_flags(6'b000010);
    tick();
    check("R10 flag pattern", flags, 6'b010101);
    for (int e = 0; e < 64; e++) begin
      irq_en = 6'(e);
      #1;
      check("R10 irq", irq, ((6'(e) & 6'b010101) != 0) ? 1 : 0);
    end
    irq_en = '0;

    // R9: reset hold
    clear_flags(6'b111100);
    for (int i = 0; i < 5; i++) begin
      tx_in_valid = 1'b1; rx_in_valid = 1'b1;
      tx_in_data = pat(i, 4); rx_in_data = pat(i, 4);
      tick();
    end
    tx_fifo_rst = 1'b1; rx_fifo_rst = 1'b1;
    tx_out_ready = 1'b1; rx_out_ready = 1'b1;
    tick();
    for (int i = 0; i < 3; i++) begin
      check("R9 tx count held 0", tx_count, 0);
      check("R9 rx count held 0", rx_count, 0);
      check("R9 tx ready low", tx_in_ready, 0);
      check("R9 rx ready low", rx_in_ready, 0);
      check("R9 tx valid low", tx_out_valid, 0);
      check("R9 rx valid low", rx_out_valid, 0);
      tick();
    end
    check("R9 no error flags", flags[5:2], 0);
    tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    tx_out_ready = 1'b0; rx_out_ready = 1'b0;
    tx_fifo_rst = 1'b0; rx_fifo_rst = 1'b0;
    tick();
    check("R9 tx empty after release", tx_count, 0);
    check("R9 rx empty after release", rx_count, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule